// File: doc/BRIEF.md
# Level-Sensitive Scan Latch Chain

This block is a scan chain built from stages that each hold two latches. The first latch (the master) has two data sources, the functional data bit and the scan data bit. Each source has its own level clock, so no select signal sits in the functional path. The clock that is pulsed decides what the master loads. The second latch (the slave) copies the master under a third clock. Each stage's slave feeds the next stage's scan input, and the slave of the last stage drives the serial scan output.

Test mode shifts data by pulsing the scan clock and then the slave clock, once per bit. A functional capture pulses the system clock and then the slave clock, which loads the whole functional vector in parallel. An elaboration option drops the slave clock input and derives the slave clock as the NOR of the two master clocks. The slave is then open whenever neither master clock is active.

The level clocks are qualified on a core clock `clk`. A latch that is open during a `clk` tick takes its source value at that tick. This keeps the model synchronous while it keeps the three-clock protocol.

Top module: `lssd_chain`

## Requirements
- R1: A high `rst` at a `clk` edge clears every master and slave latch, so `q_par` is all zero and `scan_out` is 0 after that edge.
- R2: On a tick where `ck_sys` is 1 and `ck_scan` is 0, the master of stage i loads `d_func[i]`, for every stage in parallel.
- R3: On a tick where `ck_scan` is 1 and `ck_sys` is 0, the master of stage 0 loads `scan_in` and the master of stage i (i>0) loads the slave of stage i-1.
- R4: A slave loads its master's value only on ticks where its slave clock is active, and holds otherwise. `q_par[i]` is the slave of stage i, and `scan_out` is the slave of stage CHAIN_LEN-1.
- R5: On a tick where `ck_sys` and `ck_scan` are both 1 (a protocol violation), every master holds its value.
- R6: CHAIN_LEN scan/slave pulse pairs shift a serial pattern fully in. The first bit shifted ends in `q_par[CHAIN_LEN-1]` and the last bit shifted ends in `q_par[0]`.
- R7: After a capture pair (system pulse, then slave pulse), `scan_out` shows `d_func[CHAIN_LEN-1]`. Each further shift pair shows the next lower index.
- R8: With `DERIVE_L2`=1, the slave clock is the NOR of `ck_sys` and `ck_scan`, and `ck_l2` has no effect.
- R9: On a tick where neither `ck_sys` nor `ck_scan` is 1, every master holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock that qualifies the level clocks |
| rst | input | 1 | Synchronous active-high reset |
| ck_sys | input | 1 | System level clock, opens the master to functional data |
| ck_scan | input | 1 | Scan level clock, opens the master to scan data |
| ck_l2 | input | 1 | Slave level clock (ignored when DERIVE_L2=1) |
| d_func | input | CHAIN_LEN | Functional data vector |
| scan_in | input | 1 | Serial scan input |
| q_par | output | CHAIN_LEN | Parallel outputs taken from the slaves |
| scan_out | output | 1 | Serial scan output from the last slave |

## Verification
The system clock and the scan clock are the two functions that can fall on the same tick. The bench provokes this on purpose by raising `ck_sys` and `ck_scan` together while `d_func` and the chain hold different values. It then pulses the slave clock and checks that `q_par` keeps its earlier contents, because neither source may win. A slave pulse that falls on the same tick as a master pulse is also driven. In the explicit configuration the slave must take the master's old value, and in the derived configuration the slave must stay closed on that tick.

// File: rtl/lssd_pkg.sv
package lssd_pkg;

    // Level clocks seen by one stage
    typedef struct packed {
        logic sys;
        logic scan;
        logic l2;
    } lssd_clk_t;

    // What the master latch is open to on a tick
    typedef enum logic [1:0] {
        SRC_HOLD = 2'd0,
        SRC_FUNC = 2'd1,
        SRC_SCAN = 2'd2
    } l1_src_e;

    function automatic logic nor2(input logic a, input logic b);
        return ~(a | b);
    endfunction

    // Exactly one master clock opens the latch; both or none hold it
    function automatic l1_src_e l1_select(input lssd_clk_t c);
        if (c.sys && !c.scan)
            return SRC_FUNC;
        else if (c.scan && !c.sys)
            return SRC_SCAN;
        else
            return SRC_HOLD;
    endfunction

endpackage

// File: rtl/lssd_clkgen.sv
module lssd_clkgen
    import lssd_pkg::*;
#(
    parameter bit DERIVE_L2 = 1'b0
) (
    input  logic      ck_sys,
    input  logic      ck_scan,
    input  logic      ck_l2,
    output lssd_clk_t clks
);

    generate
        if (DERIVE_L2) begin : g_nor_l2
            // Slave open whenever neither master clock is active (R8)
            assign clks = '{sys: ck_sys, scan: ck_scan, l2: nor2(ck_sys, ck_scan)};
            logic unused_l2;
            assign unused_l2 = ck_l2;
        end else begin : g_ext_l2
            assign clks = '{sys: ck_sys, scan: ck_scan, l2: ck_l2};
        end
    endgenerate

endmodule

// File: rtl/lssd_stage.sv
module lssd_stage
    import lssd_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  lssd_clk_t clks,
    input  logic      d_func,
    input  logic      scan_d,
    output logic      q
);

    logic    l1_q;
    logic    l2_q;
    l1_src_e src;

    assign src = l1_select(clks);

    always_ff @(posedge clk) begin
        if (rst) begin
            l1_q <= 1'b0;
            l2_q <= 1'b0;
        end else begin
            case (src)
                SRC_FUNC: l1_q <= d_func;
                SRC_SCAN: l1_q <= scan_d;
                default:  l1_q <= l1_q;
            endcase
            if (clks.l2)
                l2_q <= l1_q;
        end
    end

    assign q = l2_q;

    // R2: system clock alone opens master to functional data
    a_r2_func_load: assert property (@(posedge clk) disable iff (rst)
        (clks.sys && !clks.scan) |=> (l1_q == $past(d_func)));

    // R3: scan clock alone opens master to scan data
    a_r3_scan_load: assert property (@(posedge clk) disable iff (rst)
        (clks.scan && !clks.sys) |=> (l1_q == $past(scan_d)));

    // R5: overlapping master clocks leave master unchanged
    a_r5_overlap_hold: assert property (@(posedge clk) disable iff (rst)
        (clks.sys && clks.scan) |=> $stable(l1_q));

    // R9: no master clock, master holds
    a_r9_idle_hold: assert property (@(posedge clk) disable iff (rst)
        (!clks.sys && !clks.scan) |=> $stable(l1_q));

    // R4: slave closed means output holds
    a_r4_slave_hold: assert property (@(posedge clk) disable iff (rst)
        !clks.l2 |=> $stable(q));

endmodule

// File: rtl/lssd_chain.sv
module lssd_chain
    import lssd_pkg::*;
#(
    parameter int CHAIN_LEN = 8,
    parameter bit DERIVE_L2 = 1'b0
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 ck_sys,
    input  logic                 ck_scan,
    input  logic                 ck_l2,
    input  logic [CHAIN_LEN-1:0] d_func,
    input  logic                 scan_in,
    output logic [CHAIN_LEN-1:0] q_par,
    output logic                 scan_out
);

    localparam int LAST = CHAIN_LEN - 1;

    lssd_clk_t          clks;
    logic [CHAIN_LEN:0] link;

    lssd_clkgen #(.DERIVE_L2(DERIVE_L2)) u_clkgen (
        .ck_sys  (ck_sys),
        .ck_scan (ck_scan),
        .ck_l2   (ck_l2),
        .clks    (clks)
    );

    assign link[0] = scan_in;

    generate
        for (genvar i = 0; i < CHAIN_LEN; i++) begin : g_stage
            lssd_stage u_stage (
                .clk    (clk),
                .rst    (rst),
                .clks   (clks),
                .d_func (d_func[i]),
                .scan_d (link[i]),
                .q      (link[i+1])
            );
            assign q_par[i] = link[i+1];
        end
    endgenerate

    assign scan_out = link[LAST+1];

    // R1: reset empties the chain
    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> (q_par == '0 && scan_out == 1'b0));

    // R3: one shift step moves each slave into the next slave
    a_r3_shift_step: assert property (@(posedge clk) disable iff (rst)
        (ck_scan && !ck_sys && !clks.l2) ##1 (clks.l2 && !ck_sys && !ck_scan)
        |=> (q_par[0] == $past(scan_in, 2)));

endmodule

// File: tb/lssd_chain_tb.sv
module lssd_chain_tb;

    localparam int N       = 8;
    localparam int CLK_PER = 10;
    localparam int WD_MAX  = 20000;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         ck_sys = 1'b0, ck_scan = 1'b0, ck_l2 = 1'b0, scan_in = 1'b0;
    logic [N-1:0] d_func = '0;
    logic [N-1:0] q_e, q_n;
    logic         so_e, so_n;

    int checks = 0;
    int bad = 0;
    int overlaps = 0;
    int cycles = 0;
    string cur_req = "R4";

    always #(CLK_PER/2) clk = ~clk;

    lssd_chain #(.CHAIN_LEN(N), .DERIVE_L2(1'b0)) u_dut (
        .clk(clk), .rst(rst), .ck_sys(ck_sys), .ck_scan(ck_scan), .ck_l2(ck_l2),
        .d_func(d_func), .scan_in(scan_in), .q_par(q_e), .scan_out(so_e));

    lssd_chain #(.CHAIN_LEN(N), .DERIVE_L2(1'b1)) u_dut_nor (
        .clk(clk), .rst(rst), .ck_sys(ck_sys), .ck_scan(ck_scan), .ck_l2(ck_l2),
        .d_func(d_func), .scan_in(scan_in), .q_par(q_n), .scan_out(so_n));

    // Behavioural reference: index 0 explicit slave clock, 1 derived
    bit m1 [2][N];
    bit m2 [2][N];

    always @(posedge clk) begin
        for (int k = 0; k < 2; k++) begin
            bit o1 [N];
            bit o2 [N];
            bit sclk;
            for (int i = 0; i < N; i++) begin o1[i] = m1[k][i]; o2[i] = m2[k][i]; end
            sclk = (k == 0) ? ck_l2 : !(ck_sys || ck_scan);
            for (int i = 0; i < N; i++) begin
                if (rst) begin
                    m1[k][i] = 0; m2[k][i] = 0;
                end else begin
                    if (ck_sys && !ck_scan) m1[k][i] = d_func[i];
                    else if (ck_scan && !ck_sys) m1[k][i] = (i == 0) ? scan_in : o2[i-1];
                    if (sclk) m2[k][i] = o1[i];
                end
            end
        end
    end

    function automatic logic [N-1:0] model_q(int k);
        logic [N-1:0] v;
        for (int i = 0; i < N; i++) v[i] = m2[k][i];
        return v;
    endfunction

    task automatic check(string req, logic [N-1:0] act, logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    // Compare both instances with the reference on every clock
    always @(negedge clk) begin
        cycles++;
        if (ck_sys && ck_scan) begin
            overlaps++;
            $display("note: master clocks overlap (protocol error) at %0t", $time);
        end
        if (!rst) begin
            check({cur_req, " explicit"}, q_e, model_q(0));
            check({cur_req, " explicit scan_out"}, {{(N-1){1'b0}}, so_e}, {{(N-1){1'b0}}, model_q(0)[N-1]});
            check({cur_req, " R8 derived"}, q_n, model_q(1));
            check({cur_req, " R8 derived scan_out"}, {{(N-1){1'b0}}, so_n}, {{(N-1){1'b0}}, model_q(1)[N-1]});
        end
        if (cycles > WD_MAX) begin
            bad++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected<=%0d cycles", cycles, WD_MAX);
            $display("test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

    task automatic drive(logic s, logic a, logic b);
        @(negedge clk); #1;
        ck_sys = s; ck_scan = a; ck_l2 = b;
    endtask

    task automatic pulse(logic s, logic a, logic b);
        drive(s, a, b);
        drive(0, 0, 0);
    endtask

    logic [N-1:0] pat;
    logic [N-1:0] cap;
    logic [N-1:0] held;

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state seen at the ports
        cur_req = "R1";
        check("R1 reset q_par", q_e, '0);
        check("R1 reset q_par derived", q_n, '0);
        check("R1 reset scan_out", {{(N-1){1'b0}}, so_e}, '0);
        #1 rst = 1'b0;

        // R6/R3: shift a pattern, first bit ends at the far end
        cur_req = "R3";
        pat = 8'b1011_0010;
        for (int k = N-1; k >= 0; k--) begin
            @(negedge clk); #1 scan_in = pat[k];
            pulse(0, 1, 0);
            pulse(0, 0, 1);
        end
        @(negedge clk);
        check("R6 shifted pattern", q_e, pat);
        check("R6 shifted pattern derived", q_n, pat);

        // R4: a master load without a slave pulse leaves outputs alone
        cur_req = "R4";
        #1 d_func = 8'h5C;
        pulse(1, 0, 0);
        @(negedge clk);
        check("R4 slave holds without its clock", q_e, pat);

        // R2/R7: capture then shift out
        cur_req = "R2";
        pulse(0, 0, 1);
        @(negedge clk);
        check("R2 parallel capture", q_e, 8'h5C);
        cap = 8'h5C;
        cur_req = "R7";
        #1 scan_in = 1'b0;
        for (int k = N-1; k >= 0; k--) begin
            @(negedge clk);
            check("R7 scan_out order", {{(N-1){1'b0}}, so_e}, {{(N-1){1'b0}}, cap[k]});
            pulse(0, 1, 0);
            pulse(0, 0, 1);
        end

        // R5: overlapping master clocks, then slave pulse, outputs stay
        cur_req = "R5";
        @(negedge clk); #1 d_func = 8'hA7; scan_in = 1'b1;
        pulse(1, 0, 0); pulse(0, 0, 1);
        held = q_e;
        #1 d_func = 8'h18;
        pulse(1, 1, 0);
        pulse(0, 0, 1);
        @(negedge clk);
        check("R5 overlap holds master", q_e, held);

        // R9: idle then slave pulse, outputs stay
        cur_req = "R9";
        pulse(0, 0, 0);
        pulse(0, 0, 1);
        @(negedge clk);
        check("R9 idle holds master", q_e, held);

        // R8: slave pulse during a master pulse; derived slave stays closed
        cur_req = "R8";
        held = q_n;
        #1 d_func = 8'h3C;
        drive(1, 0, 1);
        @(negedge clk);
        check("R8 derived slave closed during master pulse", q_n, held);
        #1 ck_sys = 0; ck_l2 = 0;
        @(negedge clk);
        check("R8 derived slave opens when masters idle", q_n, 8'h3C);
        drive(0, 0, 0);
        repeat (2) @(negedge clk);

        $display("overlaps flagged: %0d", overlaps);
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

endmodule